// File: doc/BRIEF.md
# Multi-Channel Memory Signature Checker

This block checks memory in the background. It has four channels, and each one folds a stream of data words into a running 64-bit CRC signature. A DMA engine or a CPU delivers words through one shared write port. Each word is tagged with its channel and its size: 8, 16, 32 or 64 bits. A narrow word is zero-extended before it is compressed. Each channel holds its own settings: a 20-bit pattern limit, an expected signature, an operating mode and a timeout limit.

A channel starts on a CPU start pulse or on a pulse from a hardware timer, and every start seeds its signature to zero. The three modes differ in how a run ends:

- **Auto mode:** once the limit is reached, the channel compares the signature against the stored value. It flags a mismatch and asks the DMA for the next expected value.
- **Semi-CPU mode:** once the limit is reached, the channel raises a done interrupt and leaves the comparison to software.
- **Full-CPU mode:** the CPU feeds the words and reads the signature whenever it likes. The channel has no count limit and no watchdog.

In Auto and Semi-CPU modes a watchdog stops a channel that has not finished within its programmed number of cycles.

Top module: `sigchk_top`

## Requirements
- R1: While reset is held and right after it is released, all per-channel outputs are low and `rd_sig` reads zero for every channel.
- R2: A start seeds the channel signature to zero. Each accepted word is shifted in MSB first, 64 bits per word, through the polynomial 0x42F0E1EBA9EA3693. `rd_sig` returns the signature of the channel that `rd_ch` selects, and it shows the result of a word from the clock edge that accepts it.
- R3: `dat_size` codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits. Word bits above the coded size are compressed as zero.
- R4: A word changes the signature of the channel it addresses and of no other channel. A word addressed to a channel that is not busy changes nothing.
- R5: Auto mode (mode code 0). On the edge that accepts the word that reaches the limit, `busy` falls and `crc_req` pulses for one cycle. `fail` is set if the signature differs from the expected value, and it holds until the next start.
- R6: Semi-CPU mode (mode code 1). On completion `done_irq` pulses for one cycle. `fail` stays low and `crc_req` stays low.
- R7: Full-CPU mode (mode code 2; code 3 behaves the same). The channel stays busy regardless of the limit and of the timeout, and `trig` does not start it.
- R8: `dma_req` of a channel is high exactly while that channel is busy in Auto or Semi-CPU mode.
- R9: With a timeout limit T other than 0, an Auto or Semi-CPU channel that is still busy in its T-th cycle after the start pulses `tmo_irq` for one cycle and drops `busy`. T = 0 disables the watchdog.
- R10: If the final word arrives in the same cycle as the timeout expiry, completion wins and `tmo_irq` stays low.
- R11: A `trig` pulse starts an Auto or Semi-CPU channel in the same way as `start`. A start while the channel is busy restarts it and clears the signature, the count and `fail`.
- R12: A pattern limit of 0 completes the run on the first accepted word.
- R13: Configuration fields are written through `cfg_fld`: 0 is the pattern limit, 1 the expected signature, 2 the mode and 3 the timeout limit. After reset these fields hold the limit 0, the expected value 0, Auto mode and a disabled timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel that the configuration write targets |
| cfg_fld | input | 2 | Field select (R13) |
| cfg_data | input | 64 | Configuration value, right-aligned |
| start | input | 4 | Per-channel start pulse from the CPU |
| trig | input | 4 | Per-channel start pulse from a timer |
| dat_valid | input | 1 | Data word valid |
| dat_ch | input | 2 | Channel that the data word belongs to |
| dat_size | input | 2 | Size code of the data word (R3) |
| dat_word | input | 64 | Data word, right-aligned |
| rd_ch | input | 2 | Channel whose signature is read |
| rd_sig | output | 64 | Signature of the channel `rd_ch` selects |
| busy | output | 4 | Channel is running |
| dma_req | output | 4 | Data transfer request |
| crc_req | output | 4 | Pulse asking for the next expected value (Auto mode) |
| done_irq | output | 4 | Completion pulse (Semi-CPU mode) |
| fail | output | 4 | Signature mismatch flag (Auto mode) |
| tmo_irq | output | 4 | Timeout pulse |

## Verification
Completion of a run and expiry of its watchdog can fall in the same cycle, when the word that reaches the limit is the one that arrives in the T-th cycle after the start. The bench sets the pattern limit and the timeout to the same value and delivers the words back to back. It then expects a done pulse with no timeout pulse. A second run is one word short, so the expiry fires alone, and a word sent after the expiry must leave the signature unchanged.

// File: rtl/sigchk_pkg.sv
package sigchk_pkg;
  typedef enum logic [1:0] {
    MD_AUTO = 2'd0,
    MD_SEMI = 2'd1,
    MD_FULL = 2'd2,
    MD_FULX = 2'd3
  } md_e;

  typedef enum logic [1:0] {
    FLD_LIMIT  = 2'd0,
    FLD_EXPECT = 2'd1,
    FLD_MODE   = 2'd2,
    FLD_TMO    = 2'd3
  } fld_e;

  localparam logic [63:0] CRC64_POLY = 64'h42F0_E1EB_A9EA_3693;
endpackage

// File: rtl/sigchk_mask.sv
module sigchk_mask #(
  parameter int W = 64
) (
  input  logic [1:0]   size_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  // Keep the bits below 8 << size, force the rest to zero.
  logic [W-1:0] keep;
  int           nbits;

  always_comb begin
    nbits = 8 << size_i;
    for (int b = 0; b < W; b++) begin
      keep[b] = (b < nbits);
    end
  end

  assign word_o = word_i & keep;
endmodule

// File: rtl/sigchk_crc.sv
module sigchk_crc #(
  parameter int          W    = 64,
  parameter logic [W-1:0] POLY = sigchk_pkg::CRC64_POLY
) (
  input  logic [W-1:0] sig_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] sig_o
);
  // Bit-parallel unroll of the serial shift, most significant data bit first.
  always_comb begin
    logic [W-1:0] s;
    logic         fb;
    s = sig_i;
    for (int k = W - 1; k >= 0; k--) begin
      fb = s[W-1] ^ dat_i[k];
      s  = {s[W-2:0], 1'b0};
      if (fb) s = s ^ POLY;
    end
    sig_o = s;
  end
endmodule

// File: rtl/sigchk_chan.sv
module sigchk_chan
  import sigchk_pkg::*;
#(
  parameter int CRC_W = 64,
  parameter int CNT_W = 20,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_fld_i,
  input  logic [CRC_W-1:0] cfg_data_i,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic             acc_i,
  input  logic [CRC_W-1:0] sig_new_i,
  output logic [CRC_W-1:0] sig_o,
  output logic             busy_o,
  output logic             dma_req_o,
  output logic             crc_req_o,
  output logic             done_irq_o,
  output logic             fail_o,
  output logic             tmo_irq_o
);
  // Configuration state
  logic [CNT_W-1:0] lim_q;
  logic [CRC_W-1:0] exp_q;
  md_e              mode_q;
  logic [TO_W-1:0]  tlim_q;

  // Run state
  logic             busy_q,  busy_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic [TO_W-1:0]  tcnt_q,  tcnt_d;
  logic [CRC_W-1:0] sig_q,   sig_d;
  logic             fail_q,  fail_d;
  logic             creq_q,  creq_d;
  logic             done_q,  done_d;
  logic             tmo_q,   tmo_d;

  // Clock enables for the configuration fields
  logic en_lim, en_exp, en_mode, en_tlim;

  // Decode
  logic             is_full, is_auto, is_semi;
  logic             go, take, fin, expire;
  logic [CNT_W-1:0] cnt_inc;
  logic [TO_W-1:0]  tcnt_inc;

  assign en_lim  = cfg_we_i & (cfg_fld_i == FLD_LIMIT);
  assign en_exp  = cfg_we_i & (cfg_fld_i == FLD_EXPECT);
  assign en_mode = cfg_we_i & (cfg_fld_i == FLD_MODE);
  assign en_tlim = cfg_we_i & (cfg_fld_i == FLD_TMO);

  assign is_full  = (mode_q == MD_FULL) | (mode_q == MD_FULX);
  assign is_auto  = (mode_q == MD_AUTO);
  assign is_semi  = (mode_q == MD_SEMI);
  assign go       = start_i | (trig_i & ~is_full);
  assign take     = busy_q & acc_i;
  assign cnt_inc  = cnt_q + 1'b1;
  assign tcnt_inc = tcnt_q + 1'b1;
  assign fin      = take & ~is_full & (cnt_inc >= lim_q);
  // Completion takes priority over an expiry in the same cycle.
  assign expire   = busy_q & ~is_full & (tlim_q != '0) & (tcnt_inc == tlim_q) & ~fin;

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    tcnt_d = tcnt_q;
    sig_d  = sig_q;
    fail_d = fail_q;
    creq_d = 1'b0;
    done_d = 1'b0;
    tmo_d  = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      tcnt_d = '0;
      sig_d  = '0;
      fail_d = 1'b0;
    end else begin
      if (busy_q) tcnt_d = tcnt_inc;
      if (take) begin
        cnt_d = cnt_inc;
        sig_d = sig_new_i;
      end
      if (fin) begin
        busy_d = 1'b0;
        creq_d = is_auto;
        done_d = is_semi;
        if (is_auto) fail_d = (sig_new_i != exp_q);
      end else if (expire) begin
        busy_d = 1'b0;
        tmo_d  = 1'b1;
      end
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      exp_q  <= '0;
      mode_q <= MD_AUTO;
      tlim_q <= '0;
    end else begin
      if (en_lim)  lim_q  <= cfg_data_i[CNT_W-1:0];
      if (en_exp)  exp_q  <= cfg_data_i;
      if (en_mode) mode_q <= md_e'(cfg_data_i[1:0]);
      if (en_tlim) tlim_q <= cfg_data_i[TO_W-1:0];
    end
  end

  // Run registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tcnt_q <= '0;
      sig_q  <= '0;
      fail_q <= 1'b0;
      creq_q <= 1'b0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      tcnt_q <= tcnt_d;
      sig_q  <= sig_d;
      fail_q <= fail_d;
      creq_q <= creq_d;
      done_q <= done_d;
      tmo_q  <= tmo_d;
    end
  end

  assign sig_o      = sig_q;
  assign busy_o     = busy_q;
  assign dma_req_o  = busy_q & ~is_full;
  assign crc_req_o  = creq_q;
  assign done_irq_o = done_q;
  assign fail_o     = fail_q;
  assign tmo_irq_o  = tmo_q;
endmodule

// File: rtl/sigchk_top.sv
module sigchk_top
  import sigchk_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CRC_W = 64,
  parameter int CNT_W = 20,
  parameter int TO_W  = 16,
  parameter int CH_W  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic [1:0]       cfg_fld,
  input  logic [CRC_W-1:0] cfg_data,
  input  logic [NCH-1:0]   start,
  input  logic [NCH-1:0]   trig,
  input  logic             dat_valid,
  input  logic [CH_W-1:0]  dat_ch,
  input  logic [1:0]       dat_size,
  input  logic [CRC_W-1:0] dat_word,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [CRC_W-1:0] rd_sig,
  output logic [NCH-1:0]   busy,
  output logic [NCH-1:0]   dma_req,
  output logic [NCH-1:0]   crc_req,
  output logic [NCH-1:0]   done_irq,
  output logic [NCH-1:0]   fail,
  output logic [NCH-1:0]   tmo_irq
);
  logic [CRC_W-1:0] sig_a [NCH];
  logic [CRC_W-1:0] word_m;
  logic [CRC_W-1:0] sig_cur;
  logic [CRC_W-1:0] sig_new;

  // One shared compression engine; the port carries one word per cycle.
  sigchk_mask #(.W(CRC_W)) u_mask (
    .size_i (dat_size),
    .word_i (dat_word),
    .word_o (word_m)
  );

  assign sig_cur = sig_a[dat_ch];

  sigchk_crc #(.W(CRC_W), .POLY(CRC64_POLY[CRC_W-1:0])) u_crc (
    .sig_i (sig_cur),
    .dat_i (word_m),
    .sig_o (sig_new)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic cfg_hit, dat_hit;
    assign cfg_hit = cfg_we & (cfg_ch == CH_W'(g));
    assign dat_hit = dat_valid & (dat_ch == CH_W'(g));

    sigchk_chan #(.CRC_W(CRC_W), .CNT_W(CNT_W), .TO_W(TO_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we_i   (cfg_hit),
      .cfg_fld_i  (cfg_fld),
      .cfg_data_i (cfg_data),
      .start_i    (start[g]),
      .trig_i     (trig[g]),
      .acc_i      (dat_hit),
      .sig_new_i  (sig_new),
      .sig_o      (sig_a[g]),
      .busy_o     (busy[g]),
      .dma_req_o  (dma_req[g]),
      .crc_req_o  (crc_req[g]),
      .done_irq_o (done_irq[g]),
      .fail_o     (fail[g]),
      .tmo_irq_o  (tmo_irq[g])
    );
  end

  assign rd_sig = sig_a[rd_ch];
endmodule

// File: rtl/sigchk_chk.sv
module sigchk_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] dma_req,
  input logic [NCH-1:0] crc_req,
  input logic [NCH-1:0] done_irq,
  input logic [NCH-1:0] fail,
  input logic [NCH-1:0] tmo_irq
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[g] |-> busy[g]);

    p_tmo_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_irq[g] |=> !tmo_irq[g]);

    p_tmo_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_irq[g] |-> (!busy[g] && $past(busy[g])));

    p_fin_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_irq[g] |-> !(done_irq[g] || crc_req[g]));

    p_creq_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      crc_req[g] |-> ($past(busy[g]) && !busy[g] && !done_irq[g]));

    p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq[g] |-> ($past(busy[g]) && !busy[g] && !fail[g]));

    p_fail_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(busy[g]) && !busy[g]) |-> $stable(fail[g]));
  end
endmodule

bind sigchk_top sigchk_chk #(.NCH(NCH)) u_sigchk_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .dma_req  (dma_req),
  .crc_req  (crc_req),
  .done_irq (done_irq),
  .fail     (fail),
  .tmo_irq  (tmo_irq)
);

// File: tb/sigchk_top_tb_top.sv
`timescale 1ns/1ps
module sigchk_top_tb_top;
  localparam logic [63:0] POLY = 64'h42F0E1EBA9EA3693;
  localparam logic [63:0] GOLD = 64'h9E3779B97F4A7C15;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_ch;
  logic [1:0]  cfg_fld;
  logic [63:0] cfg_data;
  logic [3:0]  start;
  logic [3:0]  trig;
  logic        dat_valid;
  logic [1:0]  dat_ch;
  logic [1:0]  dat_size;
  logic [63:0] dat_word;
  logic [1:0]  rd_ch;
  logic [63:0] rd_sig;
  logic [3:0]  busy, dma_req, crc_req, done_irq, fail, tmo_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  sigchk_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld),
    .cfg_data(cfg_data), .start(start), .trig(trig), .dat_valid(dat_valid),
    .dat_ch(dat_ch), .dat_size(dat_size), .dat_word(dat_word), .rd_ch(rd_ch),
    .rd_sig(rd_sig), .busy(busy), .dma_req(dma_req), .crc_req(crc_req),
    .done_irq(done_irq), .fail(fail), .tmo_irq(tmo_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model, written from R2 and R3
  function automatic logic [63:0] m_step(input logic [63:0] s, input logic [63:0] d);
    for (int i = 63; i >= 0; i--) begin
      logic fb;
      fb = s[63] ^ d[i];
      s  = {s[62:0], 1'b0};
      if (fb) s = s ^ POLY;
    end
    return s;
  endfunction

  function automatic logic [63:0] m_mask(input logic [1:0] sz, input logic [63:0] w);
    case (sz)
      2'd0:    return {56'd0, w[7:0]};
      2'd1:    return {48'd0, w[15:0]};
      2'd2:    return {32'd0, w[31:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic [63:0] m_word(input logic [63:0] base, input int k);
    return base ^ (64'(k + 1) * GOLD);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] ch, input logic [1:0] fld, input logic [63:0] v);
    cfg_we = 1'b1; cfg_ch = ch; cfg_fld = fld; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_start(input logic [1:0] ch);
    start[ch] = 1'b1;
    @(negedge clk);
    start = '0;
  endtask

  task automatic do_trig(input logic [1:0] ch);
    trig[ch] = 1'b1;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic feed(input logic [1:0] ch, input logic [1:0] sz, input logic [63:0] w);
    dat_valid = 1'b1; dat_ch = ch; dat_size = sz; dat_word = w;
    @(negedge clk);
    dat_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  md;
    logic [19:0] lim;
    logic [1:0]  sz;
    logic [63:0] base;
    logic        good;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 2'd0, 20'd3, 2'd3, 64'h0123456789ABCDEF, 1'b1},
    '{2'd1, 2'd0, 20'd4, 2'd0, 64'hFFFF_FFFF_FFFF_FF5A, 1'b0},
    '{2'd2, 2'd1, 20'd2, 2'd1, 64'hDEAD_BEEF_0000_1234, 1'b1},
    '{2'd3, 2'd0, 20'd6, 2'd2, 64'hA5A5_A5A5_5A5A_5A5A, 1'b1},
    '{2'd0, 2'd1, 20'd5, 2'd2, 64'h1111_2222_3333_4444, 1'b0},
    '{2'd3, 2'd0, 20'd1, 2'd1, 64'h8000_0000_0000_8001, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] s, s4, keep3;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_fld = '0; cfg_data = '0;
    start = '0; trig = '0; dat_valid = 1'b0; dat_ch = '0; dat_size = '0;
    dat_word = '0; rd_ch = '0;
    repeat (3) @(negedge clk);
    // R1: outputs low while reset is held
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 sig in reset", rd_sig, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset",
        64'({busy, dma_req, crc_req, done_irq, fail, tmo_irq}), 64'd0);
    for (int c = 0; c < 4; c++) begin
      rd_ch = 2'(c);
      #1 chk("R1 sig zero after reset", rd_sig, 64'd0);
    end

    // Table of runs, walked by one loop
    foreach (VECS[v]) begin
      s = '0;
      for (int k = 0; k < int'(VECS[v].lim); k++)
        s = m_step(s, m_mask(VECS[v].sz, m_word(VECS[v].base, k)));
      cfg(VECS[v].ch, 2'd2, 64'(VECS[v].md));                  // R13 mode field
      cfg(VECS[v].ch, 2'd0, 64'(VECS[v].lim));                 // R13 limit field
      cfg(VECS[v].ch, 2'd1, VECS[v].good ? s : (s ^ 64'h10));  // R13 expected field
      cfg(VECS[v].ch, 2'd3, 64'd0);                            // R9 watchdog off
      rd_ch = VECS[v].ch;
      do_start(VECS[v].ch);
      chk("R11 busy after start", 64'(busy[VECS[v].ch]), 64'd1);
      chk("R8 dma_req while busy", 64'(dma_req[VECS[v].ch]), 64'd1);
      chk("R2 seed zero", rd_sig, 64'd0);
      for (int k = 0; k < int'(VECS[v].lim); k++)
        feed(VECS[v].ch, VECS[v].sz, m_word(VECS[v].base, k));
      chk("R5 R6 busy falls at limit", 64'(busy[VECS[v].ch]), 64'd0);
      chk("R8 dma_req drops", 64'(dma_req[VECS[v].ch]), 64'd0);
      chk("R2 R3 signature", rd_sig, s);
      if (VECS[v].md == 2'd0) begin
        chk("R5 fail flag", 64'(fail[VECS[v].ch]), 64'(!VECS[v].good));
        chk("R5 crc_req pulse", 64'(crc_req[VECS[v].ch]), 64'd1);
        chk("R5 no done_irq", 64'(done_irq[VECS[v].ch]), 64'd0);
      end else begin
        chk("R6 done_irq pulse", 64'(done_irq[VECS[v].ch]), 64'd1);
        chk("R6 fail low", 64'(fail[VECS[v].ch]), 64'd0);
        chk("R6 no crc_req", 64'(crc_req[VECS[v].ch]), 64'd0);
      end
      @(negedge clk);
      chk("R5 R6 pulses one cycle",
          64'({crc_req[VECS[v].ch], done_irq[VECS[v].ch]}), 64'd0);
      if (VECS[v].md == 2'd0)
        chk("R5 fail held", 64'(fail[VECS[v].ch]), 64'(!VECS[v].good));
    end

    // R12: limit zero finishes on the first word
    s = m_step(64'd0, 64'h77);
    cfg(2'd1, 2'd2, 64'd0);
    cfg(2'd1, 2'd0, 64'd0);
    cfg(2'd1, 2'd1, s);
    rd_ch = 2'd1;
    do_start(2'd1);
    chk("R11 restart clears fail", 64'(fail[1]), 64'd0);
    feed(2'd1, 2'd3, 64'h77);
    chk("R12 done after one word", 64'(busy[1]), 64'd0);
    chk("R12 match", 64'({fail[1], crc_req[1]}), 64'b01);

    // R7: Full-CPU mode
    cfg(2'd2, 2'd2, 64'd2);
    cfg(2'd2, 2'd0, 64'd1);
    cfg(2'd2, 2'd3, 64'd2);
    do_trig(2'd2);
    chk("R7 trig ignored in Full mode", 64'(busy[2]), 64'd0);
    rd_ch = 2'd2;
    do_start(2'd2);
    chk("R7 R8 no dma_req in Full mode", 64'({busy[2], dma_req[2]}), 64'b10);
    s = '0;
    for (int k = 0; k < 3; k++) begin
      feed(2'd2, 2'd3, m_word(64'h5555, k));
      s = m_step(s, m_word(64'h5555, k));
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R7 still busy past limit and timeout", 64'({busy[2], tmo_irq[2]}), 64'b10);
    chk("R7 signature readable", rd_sig, s);

    // R4: a word to an idle channel changes nothing; other channels untouched
    rd_ch = 2'd3;
    #1 keep3 = rd_sig;
    feed(2'd3, 2'd3, 64'hCAFE);
    chk("R4 idle channel ignores word", rd_sig, keep3);
    rd_ch = 2'd2;
    #1 chk("R4 busy neighbour unchanged", rd_sig, s);

    // R11: restart reseeds
    do_start(2'd2);
    chk("R11 restart reseeds", rd_sig, 64'd0);

    // R10: final word in the expiry cycle; R11 trig starts the channel
    cfg(2'd0, 2'd2, 64'd1);
    cfg(2'd0, 2'd0, 64'd5);
    cfg(2'd0, 2'd3, 64'd5);
    rd_ch = 2'd0;
    do_trig(2'd0);
    chk("R11 trig starts Semi channel", 64'(busy[0]), 64'd1);
    for (int k = 0; k < 5; k++) feed(2'd0, 2'd3, 64'(k * 3 + 1));
    chk("R10 completion wins", 64'({done_irq[0], tmo_irq[0], busy[0]}), 64'b100);

    // R9: one word short, expiry alone
    s4 = '0;
    do_start(2'd0);
    for (int k = 0; k < 4; k++) begin
      feed(2'd0, 2'd3, 64'(k + 9));
      s4 = m_step(s4, 64'(k + 9));
    end
    chk("R9 still busy before expiry", 64'({busy[0], tmo_irq[0]}), 64'b10);
    @(negedge clk);
    chk("R9 timeout pulse", 64'({tmo_irq[0], busy[0], done_irq[0]}), 64'b100);
    feed(2'd0, 2'd3, 64'hBAD);
    chk("R9 tmo one cycle", 64'(tmo_irq[0]), 64'd0);
    chk("R9 R4 word after expiry ignored", rd_sig, s4);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule